// File: doc/BRIEF.md
# Byte-Stepped I2C Master with Status Codes

This block is a single-master I2C engine that moves the bus forward one step at a time. Each step is a START, a repeated START, an address or data byte sent, a byte received, or a STOP. A small register file holds an own-address byte, a data byte, a control byte, a status byte, a clock divider byte and a soft-reset strobe. A control write requests the next step. When the step has finished on the wire, the engine sets an event flag, publishes an 8-bit code that names what happened, and keeps SCL low until software clears the flag.

SCL and SDA are open-drain. The block only pulls each line low through an output enable, and it reads SDA back through an input. The driver software never polls a busy bit. It waits for the flag, compares the status code with the one it expects, and then writes the control byte that clears the flag and launches the next step. A build parameter selects how the flag is cleared: by writing a one to the flag bit, or by writing a zero to it.

Top module: `twi_master`

## Requirements
- R1: After reset the status reads 0xF8, control reads 0x00, the divider reads 0x44, the own-address reads 0x00, irq is low and neither line is pulled.
- R2: Register offsets are 0 own-address, 1 data, 2 control, 3 status (read only), 4 divider, 5 soft reset (write only). Control bits are ACK enable at bit 2, flag at bit 3, STOP at bit 4, START at bit 5, enable at bit 6 and interrupt enable at bit 7. irq is high exactly when both the flag and interrupt enable are set.
- R3: A control write with enable and START, made while the bus is idle, sends a START, then sets the flag with status 0x08. SCL stays pulled low for as long as the flag is set.
- R4: A START requested while a transfer is open, before any STOP, reports 0x10.
- R5: The first byte sent after a START is the address byte, and its bit 0 gives the direction (1 = read). The status reports 0x18 for write with ACK, 0x20 for write with NAK, 0x40 for read with ACK and 0x48 for read with NAK.
- R6: Any later byte sent is taken from the data register, is shifted out MSB first, and reports 0x28 on ACK or 0x30 on NAK.
- R7: After status 0x40 or 0x50, clearing the flag receives a byte into the data register. If ACK enable is set in that same control write, the engine drives ACK and reports 0x50. If it is clear, the engine leaves NAK and reports 0x58.
- R8: A STOP request releases both lines and returns the status to 0xF8 without setting the flag.
- R9: With FLAG_W1C=1, writing 1 to bit 3 clears the flag. With FLAG_W1C=0, writing 0 to bit 3 clears it. A control write that does not clear the flag leaves the flag and status unchanged and launches nothing.
- R10: Any write to offset 5 aborts activity, releases both lines, clears control and flag, sets the status to 0xF8, and restores the divider to 0x44 and the own-address to 0x00.
- R11: With divider fields m = bits 6:3 and n = bits 2:0, one quarter bit lasts (m+1)·2^n clocks. A START sets the flag exactly 4 quarters after the launching write, and a byte takes 36 quarters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The register write is captured on edge E0. The tick counter is loaded on that same edge, so a quarter-bit tick arrives every (m+1)·2^n edges after it. A START therefore sets the flag on edge E0+4(m+1)·2^n, and a byte sets it 36 quarters after E0. The timing check uses divider 0x09 and samples the flag on the falling edge after E15, where it must be low, and after E16, where it must be high. Every other step waits for the flag by polling, with a bound, and only then compares the status, the data register and the bytes seen by the slave model. A STOP raises no flag, so the bench waits a fixed margin longer than four quarters before it checks the idle code and the released lines.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int DIV_W = 12;

    localparam logic [2:0] REG_OWN  = 3'd0;
    localparam logic [2:0] REG_DATA = 3'd1;
    localparam logic [2:0] REG_CTRL = 3'd2;
    localparam logic [2:0] REG_STAT = 3'd3;
    localparam logic [2:0] REG_BAUD = 3'd4;
    localparam logic [2:0] REG_SRST = 3'd5;

    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IEN   = 7;

    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AW_ACK = 8'h18;
    localparam logic [7:0] ST_AW_NAK = 8'h20;
    localparam logic [7:0] ST_DW_ACK = 8'h28;
    localparam logic [7:0] ST_DW_NAK = 8'h30;
    localparam logic [7:0] ST_AR_ACK = 8'h40;
    localparam logic [7:0] ST_AR_NAK = 8'h48;
    localparam logic [7:0] ST_DR_ACK = 8'h50;
    localparam logic [7:0] ST_DR_NAK = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} twi_op_e;

    typedef struct packed {
        twi_op_e    op;
        logic [7:0] tx;
        logic       ack_en;
    } twi_cmd_t;

    // Clocks per quarter bit minus one: (m+1) << n, less one.
    function automatic logic [DIV_W-1:0] quarter_load(input logic [6:0] baud);
        logic [DIV_W-1:0] span;
        span = ({{(DIV_W-4){1'b0}}, baud[6:3]} + 1'b1) << baud[2:0];
        return span - 1'b1;
    endfunction

    function automatic logic [7:0] done_code(input twi_op_e op, input logic in_txn,
                                             input logic addr_ph, input logic rd_bit,
                                             input logic acked, input logic ack_en);
        logic [7:0] c;
        case (op)
            OP_START: c = in_txn ? ST_RSTART : ST_START;
            OP_TX: begin
                if (addr_ph && rd_bit)  c = acked ? ST_AR_ACK : ST_AR_NAK;
                else if (addr_ph)       c = acked ? ST_AW_ACK : ST_AW_NAK;
                else                    c = acked ? ST_DW_ACK : ST_DW_NAK;
            end
            OP_RX:   c = ack_en ? ST_DR_ACK : ST_DR_NAK;
            default: c = ST_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/twi_qtick.sv
module twi_qtick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] load,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run)          cnt_q <= load;
        else if (cnt_q == '0)     cnt_q <= load;
        else                      cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/twi_bitseq.sv
module twi_bitseq
    import twi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       launch,
    input  twi_cmd_t   cmd,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic       acked,
    output logic [7:0] rx_byte,
    output logic       scl_oe,
    output logic       sda_oe
);
    twi_op_e    op_q;
    logic       ack_en_q;
    logic [1:0] phase_q;
    logic [3:0] bit_q;
    logic [7:0] sh_q;
    logic       hold_scl_q, hold_sda_q;

    localparam logic [3:0] ACK_SLOT = 4'd8;

    logic byte_op, last_bit;
    assign byte_op  = (op_q == OP_TX) || (op_q == OP_RX);
    assign last_bit = !byte_op || (bit_q == ACK_SLOT);
    assign done     = busy && tick && (phase_q == 2'd3) && last_bit;
    assign rx_byte  = sh_q;

    // Line drive per operation and quarter.
    always_comb begin
        if (!busy) begin
            scl_oe = hold_scl_q;
            sda_oe = hold_sda_q;
        end else begin
            case (op_q)
                OP_START: begin
                    scl_oe = (phase_q == 2'd0);
                    sda_oe = (phase_q >= 2'd2);
                end
                OP_STOP: begin
                    scl_oe = (phase_q == 2'd0);
                    sda_oe = (phase_q < 2'd2);
                end
                OP_TX: begin
                    scl_oe = (phase_q < 2'd2);
                    sda_oe = (bit_q == ACK_SLOT) ? 1'b0 : !sh_q[7];
                end
                default: begin
                    scl_oe = (phase_q < 2'd2);
                    sda_oe = (bit_q == ACK_SLOT) ? ack_en_q : 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy       <= 1'b0;
            op_q       <= OP_STOP;
            ack_en_q   <= 1'b0;
            phase_q    <= 2'd0;
            bit_q      <= 4'd0;
            sh_q       <= 8'h00;
            acked      <= 1'b0;
            hold_scl_q <= 1'b0;
            hold_sda_q <= 1'b0;
        end else if (launch && !busy) begin
            busy     <= 1'b1;
            op_q     <= cmd.op;
            ack_en_q <= cmd.ack_en;
            sh_q     <= cmd.tx;
            phase_q  <= 2'd0;
            bit_q    <= 4'd0;
        end else if (busy && tick) begin
            phase_q <= phase_q + 2'd1;
            if (phase_q == 2'd2 && byte_op) begin
                if (bit_q == ACK_SLOT)   acked <= !sda_in;
                else if (op_q == OP_RX)  sh_q  <= {sh_q[6:0], sda_in};
            end
            if (phase_q == 2'd3) begin
                if (last_bit) begin
                    busy       <= 1'b0;
                    hold_scl_q <= (op_q != OP_STOP);
                    hold_sda_q <= sda_oe;
                end else begin
                    bit_q <= bit_q + 4'd1;
                    if (op_q == OP_TX) sh_q <= {sh_q[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/twi_master.sv
module twi_master
    import twi_pkg::*;
#(
    parameter bit         FLAG_W1C = 1'b1,
    parameter logic [7:0] BAUD_RST = 8'h44
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic [7:0] own_q, data_q, baud_q, status_q;
    logic       flag_q, ack_q, en_q, ien_q;
    logic       in_txn_q, addr_ph_q;
    twi_op_e    cur_op_q;
    logic       cur_ack_q, cur_rd_q;

    logic       seq_busy, seq_done, seq_acked, qtick;
    logic [7:0] rx_byte;
    twi_cmd_t   cmd;

    logic srst, wr_ctrl, clears, flag_clear_ev, idle_start, launch;

    assign srst          = reg_wr && (reg_addr == REG_SRST);
    assign wr_ctrl       = reg_wr && (reg_addr == REG_CTRL);
    assign clears        = FLAG_W1C ? reg_wdata[CB_FLAG] : !reg_wdata[CB_FLAG];
    assign flag_clear_ev = wr_ctrl && flag_q && clears;
    assign idle_start    = wr_ctrl && !flag_q && (status_q == ST_IDLE) && reg_wdata[CB_START];
    assign launch        = reg_wdata[CB_EN] && (flag_clear_ev || idle_start) && !seq_busy;

    always_comb begin
        cmd.tx     = data_q;
        cmd.ack_en = reg_wdata[CB_ACK];
        if (reg_wdata[CB_START])                                 cmd.op = OP_START;
        else if (reg_wdata[CB_STOP])                             cmd.op = OP_STOP;
        else if (status_q == ST_AR_ACK || status_q == ST_DR_ACK) cmd.op = OP_RX;
        else                                                     cmd.op = OP_TX;
    end

    twi_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst || srst),
        .run  (seq_busy),
        .load (quarter_load(baud_q[6:0])),
        .tick (qtick)
    );

    twi_bitseq u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (srst),
        .launch  (launch),
        .cmd     (cmd),
        .tick    (qtick),
        .sda_in  (sda_in),
        .busy    (seq_busy),
        .done    (seq_done),
        .acked   (seq_acked),
        .rx_byte (rx_byte),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            own_q     <= 8'h00;
            data_q    <= 8'h00;
            baud_q    <= BAUD_RST;
            status_q  <= ST_IDLE;
            flag_q    <= 1'b0;
            ack_q     <= 1'b0;
            en_q      <= 1'b0;
            ien_q     <= 1'b0;
            in_txn_q  <= 1'b0;
            addr_ph_q <= 1'b0;
            cur_op_q  <= OP_STOP;
            cur_ack_q <= 1'b0;
            cur_rd_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    REG_OWN:  own_q  <= reg_wdata;
                    REG_DATA: data_q <= reg_wdata;
                    REG_BAUD: baud_q <= reg_wdata;
                    REG_CTRL: begin
                        ack_q <= reg_wdata[CB_ACK];
                        en_q  <= reg_wdata[CB_EN];
                        ien_q <= reg_wdata[CB_IEN];
                    end
                    default: ;
                endcase
            end
            if (flag_clear_ev) flag_q <= 1'b0;
            if (launch) begin
                cur_op_q  <= cmd.op;
                cur_ack_q <= cmd.ack_en;
                cur_rd_q  <= data_q[0];
            end
            if (seq_done) begin
                status_q <= done_code(cur_op_q, in_txn_q, addr_ph_q, cur_rd_q,
                                      seq_acked, cur_ack_q);
                flag_q   <= (cur_op_q != OP_STOP);
                case (cur_op_q)
                    OP_START: begin in_txn_q <= 1'b1; addr_ph_q <= 1'b1; end
                    OP_TX:    addr_ph_q <= 1'b0;
                    OP_RX:    data_q <= rx_byte;
                    default:  begin in_txn_q <= 1'b0; addr_ph_q <= 1'b0; end
                endcase
            end
        end
    end

    assign irq = flag_q && ien_q;

    always_comb begin
        case (reg_addr)
            REG_OWN:  reg_rdata = own_q;
            REG_DATA: reg_rdata = data_q;
            REG_CTRL: reg_rdata = {ien_q, en_q, 2'b00, flag_q, ack_q, 2'b00};
            REG_STAT: reg_rdata = status_q;
            REG_BAUD: reg_rdata = baud_q;
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/twi_master_chk.sv
module twi_master_chk
    import twi_pkg::*;
#(
    parameter logic [7:0] BAUD_RST = 8'h44
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       flag_q,
    input logic       seq_busy,
    input logic       seq_done,
    input twi_op_e    cur_op_q,
    input logic [7:0] status_q,
    input logic [7:0] baud_q,
    input logic       scl_oe
);
    logic srst_w;
    assign srst_w = reg_wr && (reg_addr == REG_SRST);

    assert_hold_scl_R3: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> scl_oe);

    assert_no_step_under_flag_R9: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> !seq_busy);

    assert_flag_after_step_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_done && cur_op_q != OP_STOP && !srst_w) |=> flag_q);

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_done && cur_op_q == OP_STOP) |=> (status_q == ST_IDLE && !flag_q && !scl_oe));

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
        srst_w |=> (!seq_busy && !flag_q && status_q == ST_IDLE && baud_q == BAUD_RST));
endmodule

bind twi_master twi_master_chk #(.BAUD_RST(BAUD_RST)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .flag_q   (flag_q),
    .seq_busy (seq_busy),
    .seq_done (seq_done),
    .cur_op_q (cur_op_q),
    .status_q (status_q),
    .baud_q   (baud_q),
    .scl_oe   (scl_oe)
);

// File: tb/tb_twi_master.sv
module tb_twi_master;
    import twi_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq, scl_oe, sda_oe, sda_in;

    logic       b_wr;
    logic [2:0] b_addr;
    logic [7:0] b_wdata, b_rdata;
    logic       b_irq, b_scl_oe, b_sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Slave model state
    logic       pull, slv_ack, m_ack;
    logic [7:0] slv_tx, slv_last, s_sh;
    logic       s_act, s_fresh, s_rd, s_quiet, p_scl, p_sda;
    int         s_bit, s_byte;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || pull);
    assign sda_in   = sda_line;

    twi_master dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    twi_master #(.FLAG_W1C(1'b0)) dut_w0 (
        .clk(clk), .rst(rst), .reg_wr(b_wr), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(b_rdata), .irq(b_irq),
        .scl_oe(b_scl_oe), .sda_oe(b_sda_oe), .sda_in(!b_sda_oe)
    );

    always_comb begin
        if (!s_act || s_fresh)        pull = 1'b0;
        else if (s_byte == 0 || !s_rd) pull = (s_bit == 8) && slv_ack;
        else if (s_quiet)             pull = 1'b0;
        else                          pull = (s_bit < 8) ? !slv_tx[3'(7 - s_bit)] : 1'b0;
    end

    always @(negedge clk) begin
        if (rst) begin
            s_act <= 0; s_fresh <= 0; s_rd <= 0; s_quiet <= 0;
            s_bit <= 0; s_byte <= 0; s_sh <= 0; slv_last <= 0; m_ack <= 0;
            p_scl <= 1; p_sda <= 1;
        end else begin
            p_scl <= scl_line;
            p_sda <= sda_line;
            if (p_scl && scl_line && p_sda && !sda_line) begin
                s_act <= 1; s_fresh <= 1; s_bit <= 0; s_byte <= 0; s_rd <= 0; s_quiet <= 0;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                s_act <= 0; s_fresh <= 0; s_bit <= 0; s_byte <= 0; s_rd <= 0; s_quiet <= 0;
            end else if (s_act && !p_scl && scl_line && !s_fresh) begin
                if (s_bit < 8)                   s_sh <= {s_sh[6:0], sda_line};
                else if (s_byte == 0 || !s_rd)   slv_last <= s_sh;
                else begin
                    m_ack <= !sda_line;
                    if (sda_line) s_quiet <= 1;
                end
            end else if (s_act && p_scl && !scl_line) begin
                if (s_fresh) begin
                    s_fresh <= 0; s_bit <= 0;
                end else if (s_bit == 8) begin
                    s_bit <= 0;
                    if (s_byte == 0) s_rd <= s_sh[0];
                    if ((s_byte == 0 || !s_rd) && !slv_ack) s_quiet <= 1;
                    s_byte <= s_byte + 1;
                end else begin
                    s_bit <= s_bit + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        logic [7:0] v;
        v = 8'h00;
        for (int i = 0; i < 600; i++) begin
            rd(REG_CTRL, v);
            if (v[CB_FLAG]) break;
        end
        check(req, {7'd0, v[CB_FLAG]}, 8'h01);
    endtask

    // op: 0 START, 1 TX, 2 RX with ACK, 3 RX with NAK, 4 STOP
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] byt;
        logic       sack;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h00, 1'b0, 8'h08},
        '{3'd1, 8'hA4, 1'b1, 8'h18},
        '{3'd1, 8'h3C, 1'b1, 8'h28},
        '{3'd1, 8'h81, 1'b0, 8'h30},
        '{3'd0, 8'h00, 1'b0, 8'h10},
        '{3'd1, 8'hA5, 1'b1, 8'h40},
        '{3'd2, 8'h96, 1'b0, 8'h50},
        '{3'd3, 8'h5A, 1'b0, 8'h58},
        '{3'd4, 8'h00, 1'b0, 8'hF8},
        '{3'd0, 8'h00, 1'b0, 8'h08},
        '{3'd1, 8'hA4, 1'b0, 8'h20},
        '{3'd4, 8'h00, 1'b0, 8'hF8},
        '{3'd0, 8'h00, 1'b0, 8'h08},
        '{3'd1, 8'hA5, 1'b0, 8'h48},
        '{3'd4, 8'h00, 1'b0, 8'hF8}
    };

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        b_wr = 0; b_addr = 0; b_wdata = 0;
        slv_ack = 0; slv_tx = 0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(REG_STAT, v); check("R1 status", v, 8'hF8);
        rd(REG_CTRL, v); check("R1 control", v, 8'h00);
        rd(REG_BAUD, v); check("R1 divider", v, 8'h44);
        rd(REG_OWN, v);  check("R1 own", v, 8'h00);
        check("R1 lines/irq", {5'd0, irq, scl_oe, sda_oe}, 8'h00);

        wr(REG_BAUD, 8'h00);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            slv_ack = VEC[k].sack;
            slv_tx  = VEC[k].byt;
            case (VEC[k].op)
                3'd0: wr(REG_CTRL, 8'h68);
                3'd1: begin wr(REG_DATA, VEC[k].byt); wr(REG_CTRL, 8'h48); end
                3'd2: wr(REG_CTRL, 8'h4C);
                3'd3: wr(REG_CTRL, 8'h48);
                default: wr(REG_CTRL, 8'h58);
            endcase
            if (VEC[k].op == 3'd4) begin
                repeat (12) @(negedge clk);
                rd(REG_CTRL, v); check("R8 no flag after stop", {7'd0, v[CB_FLAG]}, 8'h00);
                check("R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
            end else begin
                wait_flag("R3 flag raised");
            end
            rd(REG_STAT, v); check("R5 status code", v, VEC[k].exp);
            if (VEC[k].op == 3'd1) check("R6 byte on wire", slv_last, VEC[k].byt);
            if (VEC[k].op == 3'd2 || VEC[k].op == 3'd3) begin
                rd(REG_DATA, v); check("R7 received byte", v, VEC[k].byt);
                check("R7 ack driven", {7'd0, m_ack}, {7'd0, VEC[k].op == 3'd2});
            end
        end

        // R2 irq and control readback; R9 non-clearing write
        wr(REG_CTRL, 8'hE8);
        wait_flag("R2 flag");
        check("R2 irq", {7'd0, irq}, 8'h01);
        rd(REG_CTRL, v); check("R2 control readback", v, 8'hC8);
        wr(REG_CTRL, 8'h40);
        repeat (50) @(negedge clk);
        check("R2 irq off", {7'd0, irq}, 8'h00);
        rd(REG_CTRL, v); check("R9 flag kept", {7'd0, v[CB_FLAG]}, 8'h01);
        rd(REG_STAT, v); check("R9 no launch", v, 8'h08);
        check("R3 scl held", {7'd0, scl_oe}, 8'h01);
        wr(REG_CTRL, 8'h58);
        repeat (12) @(negedge clk);
        rd(REG_STAT, v); check("R8 idle", v, 8'hF8);

        // R11 exact START timing with divider 0x09 (quarter = 4 clocks)
        wr(REG_BAUD, 8'h09);
        wr(REG_CTRL, 8'h68);
        repeat (15) @(negedge clk);
        check("R11 flag not yet", {7'd0, irq, dut.reg_rdata == 8'h00}, 8'h00 | {7'd0, 1'b0});
        reg_addr = REG_CTRL; #1;
        check("R11 flag before 16", {7'd0, reg_rdata[CB_FLAG]}, 8'h00);
        @(negedge clk); #1;
        check("R11 flag at 16", {7'd0, reg_rdata[CB_FLAG]}, 8'h01);
        wr(REG_CTRL, 8'h58);
        repeat (40) @(negedge clk);
        rd(REG_STAT, v); check("R11 stop done", v, 8'hF8);

        // R10 soft reset while holding the bus
        wr(REG_OWN, 8'h55);
        wr(REG_BAUD, 8'h13);
        wr(REG_CTRL, 8'h68);
        wait_flag("R10 pre flag");
        wr(REG_SRST, 8'h00);
        rd(REG_STAT, v); check("R10 status", v, 8'hF8);
        rd(REG_CTRL, v); check("R10 control", v, 8'h00);
        rd(REG_BAUD, v); check("R10 divider", v, 8'h44);
        rd(REG_OWN, v);  check("R10 own", v, 8'h00);
        check("R10 lines", {6'd0, scl_oe, sda_oe}, 8'h00);

        // R9 write-zero-to-clear variant
        bwr(REG_BAUD, 8'h00);
        bwr(REG_CTRL, 8'h60);
        repeat (20) @(negedge clk);
        b_addr = REG_CTRL; #1;
        check("R9 w0 flag set", {7'd0, b_rdata[CB_FLAG]}, 8'h01);
        bwr(REG_CTRL, 8'h48);
        repeat (20) @(negedge clk);
        b_addr = REG_CTRL; #1;
        check("R9 w0 one keeps flag", {7'd0, b_rdata[CB_FLAG]}, 8'h01);
        b_addr = REG_STAT; #1;
        check("R9 w0 status kept", b_rdata, 8'h08);
        bwr(REG_CTRL, 8'h50);
        repeat (20) @(negedge clk);
        b_addr = REG_STAT; #1;
        check("R9 w0 zero clears and stops", b_rdata, 8'hF8);
        check("R9 w0 lines", {6'd0, b_scl_oe, b_sda_oe}, 8'h00);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule